// File: doc/BRIEF.md
# SD Command Descriptor Encoder

This block converts one high-level SD/MMC command request into the values a host controller needs to start that command. It produces a packed send word, an interrupt-enable mask, a packet-length setting, a manual-stop flag and a registered copy of the command argument. The request carries the opcode, the argument, a data flag with block count, block size and direction, the response flags (present, 136-bit, CRC-checked, busy) and a flush-mode select.

A one-cycle `req_valid` strobe captures the request. The encoded results appear on the next clock edge, together with a one-cycle `out_valid` pulse. They then hold until the next request. The SD bus, DMA engine and register file sit outside this block.

Top module: `sd_cmd_encoder`

## Requirements
- R1: A cycle with `req_valid` high is followed on the next clock edge by exactly one cycle of `out_valid` high. `out_valid` is never high unless `req_valid` was high in the cycle before.
- R2: Reset clears every output to zero. Without a request, all encoded outputs keep their values.
- R3: `send_word[5:0]` carries the opcode and `arg_out` carries the argument.
- R4: `send_word[9]` is the data flag. With data, `send_word[31:16]` holds the block count minus one. Without data it holds zero.
- R5: `pack_len` equals the block size when the block size is below 512. It is 0 when the block size is 512 or more, and 0 for a command without data.
- R6: `send_word[10]` is set only for a write that carries data.
- R7: `send_word[12]` (data stop) is set exactly when the opcode is 12.
- R8: `send_word[6]` mirrors response-present. `send_word[7]` mirrors 136-bit response. `send_word[8]` (no CRC) is set when the response is 136-bit or CRC checking is not requested.
- R9: `send_word[11]` mirrors the busy-response flag. Send-word bits 15:13 are always zero.
- R10: `manual_stop` is high only for opcode 53 with data and a block count greater than 1.
- R11: The interrupt mask always sets bits 1 to 6: response CRC, response timeout, data CRC, data timeout, RX FIFO full and TX FIFO empty. Without data, it also sets bit 0 (response OK).
- R12: With data, the mask sets bit 8 (DMA done) when `hw_flush` is high or the transfer is a write. Otherwise it sets bit 7 (transfer OK). Exactly one of bits 0, 7 and 8 is set on every valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| opcode | input | 6 | Command index |
| arg | input | 32 | Command argument |
| has_data | input | 1 | Command moves data |
| blk_cnt | input | CNT_W | Number of blocks (at least 1 with data) |
| blk_size | input | BSZ_W | Bytes per block |
| is_write | input | 1 | Data direction: 1 = write |
| rsp_present | input | 1 | Response expected |
| rsp_long | input | 1 | 136-bit response |
| rsp_crc | input | 1 | Response CRC checked |
| rsp_busy | input | 1 | Busy signalled after response |
| hw_flush | input | 1 | Hardware flush mode for all data commands |
| out_valid | output | 1 | One-cycle result strobe |
| send_word | output | 32 | Packed send word |
| irq_mask | output | 9 | Interrupt-enable mask |
| pack_len | output | PLEN_W | Packet length field |
| manual_stop | output | 1 | Manual-stop control |
| arg_out | output | 32 | Registered argument |

## Verification
The assertions assume that a request with data carries a block count of at least 1. They also assume that requests arrive no more often than one per cycle and that inputs are stable around the capturing edge. The bench drives every request on a falling edge, holds it for one cycle and always gives a non-zero block count when the data flag is set. Block sizes in the bench cover values below, at and above 512. Block counts of 1 and more than 1 are exercised for opcode 53.

// File: rtl/sd_cmd_encoder.sv
module sd_cmd_encoder #(
  parameter int CNT_W   = 16,
  parameter int BSZ_W   = 10,
  parameter int MAX_BLK = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [5:0]         opcode,
  input  logic [31:0]        arg,
  input  logic               has_data,
  input  logic [CNT_W-1:0]   blk_cnt,
  input  logic [BSZ_W-1:0]   blk_size,
  input  logic               is_write,
  input  logic               rsp_present,
  input  logic               rsp_long,
  input  logic               rsp_crc,
  input  logic               rsp_busy,
  input  logic               hw_flush,
  output logic               out_valid,
  output logic [31:0]        send_word,
  output logic [8:0]         irq_mask,
  output logic [$clog2(MAX_BLK)-1:0] pack_len,
  output logic               manual_stop,
  output logic [31:0]        arg_out
);
  localparam int PLEN_W = $clog2(MAX_BLK);
  localparam logic [5:0] OP_STOP = 6'd12;
  localparam logic [5:0] OP_EXT  = 6'd53;
  localparam logic [8:0] IRQ_BASE = 9'b0_0111_1110;

  logic [15:0]       tot_pack;
  logic [31:0]       send_d;
  logic [8:0]        mask_d;
  logic [PLEN_W-1:0] plen_d;
  logic              mstop_d;
  logic              dma_done_sel;

  assign tot_pack = has_data ? 16'(blk_cnt - CNT_W'(1)) : 16'd0;

  assign send_d = {tot_pack, 3'b000,
                   opcode == OP_STOP,
                   rsp_busy,
                   has_data & is_write,
                   has_data,
                   rsp_long | ~rsp_crc,
                   rsp_long,
                   rsp_present,
                   opcode};

  assign plen_d = (has_data && blk_size < BSZ_W'(MAX_BLK)) ?
                  PLEN_W'(blk_size) : '0;

  assign dma_done_sel = hw_flush | is_write;

  assign mask_d = IRQ_BASE | (has_data ? (dma_done_sel ? 9'h100 : 9'h080) : 9'h001);

  assign mstop_d = has_data && opcode == OP_EXT && blk_cnt > CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      send_word   <= '0;
      irq_mask    <= '0;
      pack_len    <= '0;
      manual_stop <= 1'b0;
      arg_out     <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        send_word   <= send_d;
        irq_mask    <= mask_d;
        pack_len    <= plen_d;
        manual_stop <= mstop_d;
        arg_out     <= arg;
      end
    end
  end
endmodule

// File: rtl/sd_cmd_encoder_chk.sv
module sd_cmd_encoder_chk #(
  parameter int PLEN_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              out_valid,
  input logic [31:0]       send_word,
  input logic [8:0]        irq_mask,
  input logic [PLEN_W-1:0] pack_len,
  input logic              manual_stop,
  input logic [31:0]       arg_out
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R1
  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(req_valid)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(send_word) && $stable(irq_mask) && $stable(pack_len) && $stable(arg_out)); // R2
  AST_NODATA_PLEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !send_word[9] |-> pack_len == '0 && send_word[31:16] == 16'd0); // R5
  AST_WRITE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && send_word[10] |-> send_word[9]); // R6
  AST_LONG_NOCRC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && send_word[7] |-> send_word[8]); // R8
  AST_MSTOP_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && manual_stop |-> send_word[5:0] == 6'd53 && send_word[9] && send_word[31:16] != 16'd0); // R10
  AST_IRQ_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> irq_mask[6:1] == 6'h3f); // R11
  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({irq_mask[8], irq_mask[7], irq_mask[0]}) == 1); // R12
  AST_DONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> irq_mask[0] == !send_word[9]); // R11
endmodule

bind sd_cmd_encoder sd_cmd_encoder_chk #(.PLEN_W(PLEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .out_valid(out_valid),
  .send_word(send_word), .irq_mask(irq_mask), .pack_len(pack_len),
  .manual_stop(manual_stop), .arg_out(arg_out)
);

// File: tb/sd_cmd_encoder_tb.sv
module sd_cmd_encoder_tb;
  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [5:0] opcode = 0;
  logic [31:0] arg = 0;
  logic has_data = 0, is_write = 0, rsp_present = 0, rsp_long = 0;
  logic rsp_crc = 0, rsp_busy = 0, hw_flush = 0;
  logic [15:0] blk_cnt = 0;
  logic [9:0] blk_size = 0;
  logic out_valid, manual_stop;
  logic [31:0] send_word, arg_out;
  logic [8:0] irq_mask, pack_len;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  sd_cmd_encoder u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] op, input logic [31:0] a, input logic d,
                       input logic [15:0] n, input logic [9:0] bs, input logic w,
                       input logic p, input logic l, input logic c, input logic b,
                       input logic f);
    logic [31:0] es; logic [8:0] em; logic [8:0] ep; logic ms;
    @(negedge clk);
    opcode = op; arg = a; has_data = d; blk_cnt = n; blk_size = bs; is_write = w;
    rsp_present = p; rsp_long = l; rsp_crc = c; rsp_busy = b; hw_flush = f;
    req_valid = 1;
    es = 0;
    es[5:0] = op; es[6] = p; es[7] = l; es[8] = l | ~c; es[9] = d;
    es[10] = d & w; es[11] = b; es[12] = (op == 6'd12);
    es[31:16] = d ? n - 16'd1 : 16'd0;
    ep = (d && bs < 10'd512) ? bs[8:0] : 9'd0;
    em = 9'h07e;
    if (!d) em[0] = 1; else if (f || w) em[8] = 1; else em[7] = 1;
    ms = d && op == 6'd53 && n > 1;
    @(negedge clk);
    req_valid = 0;
    chk("R1 out_valid", {31'd0, out_valid}, 32'd1);
    chk("R3 opcode", {26'd0, send_word[5:0]}, {26'd0, op});
    chk("R3 arg_out", arg_out, a);
    chk("R4 total pack/data", {send_word[31:16], 6'd0, send_word[9], 9'd0}, {es[31:16], 6'd0, es[9], 9'd0});
    chk("R5 pack_len", {23'd0, pack_len}, {23'd0, ep});
    chk("R6 dir", {31'd0, send_word[10]}, {31'd0, es[10]});
    chk("R7 stop", {31'd0, send_word[12]}, {31'd0, es[12]});
    chk("R8 resp bits", {29'd0, send_word[8:6]}, {29'd0, es[8:6]});
    chk("R9 busy/reserved", {28'd0, send_word[15:13], send_word[11]}, {28'd0, 3'd0, es[11]});
    chk("R10 manual_stop", {31'd0, manual_stop}, {31'd0, ms});
    chk("R11 irq base", {26'd0, irq_mask[6:0]}, {26'd0, em[6:0]});
    chk("R12 irq done", {30'd0, irq_mask[8:7]}, {30'd0, em[8:7]});
    es[31:0] = send_word;
    @(negedge clk);
    chk("R1 single pulse", {31'd0, out_valid}, 32'd0);
    chk("R2 hold", send_word, es);
  endtask

  task automatic t_reset;
    chk("R2 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R2 reset send", send_word, 32'd0);
    chk("R2 reset mask", {23'd0, irq_mask}, 32'd0);
    chk("R2 reset plen", {23'd0, pack_len}, 32'd0);
  endtask

  task automatic t_nodata;  issue(6'd0, 32'h0, 0, 0, 0, 0, 0, 0, 1, 0, 0); endtask
  task automatic t_short;   issue(6'd13, 32'h1234_0000, 0, 5, 64, 1, 1, 0, 1, 0, 0); endtask
  task automatic t_long;    issue(6'd2, 32'hdead_beef, 0, 0, 0, 0, 1, 1, 1, 0, 0); endtask
  task automatic t_nocrc;   issue(6'd41, 32'h00ff_8000, 0, 0, 0, 0, 1, 0, 0, 0, 0); endtask
  task automatic t_rd512;   issue(6'd17, 32'h0000_0100, 1, 1, 512, 0, 1, 0, 1, 0, 0); endtask
  task automatic t_rdflush; issue(6'd18, 32'h0000_0200, 1, 4, 511, 0, 1, 0, 1, 0, 1); endtask
  task automatic t_wr;      issue(6'd25, 32'h0001_0000, 1, 8, 64, 1, 1, 0, 1, 0, 0); endtask
  task automatic t_big;     issue(6'd24, 32'h0, 1, 16'hffff, 600, 1, 1, 0, 1, 0, 1); endtask
  task automatic t_ext_m;   issue(6'd53, 32'h9000_0004, 1, 3, 4, 1, 1, 0, 1, 0, 0); endtask
  task automatic t_ext_1;   issue(6'd53, 32'h1000_0004, 1, 1, 4, 0, 1, 0, 1, 0, 0); endtask
  task automatic t_other_m; issue(6'd18, 32'h5, 1, 2, 512, 0, 1, 0, 1, 0, 0); endtask
  task automatic t_stop;    issue(6'd12, 32'h0, 0, 0, 0, 0, 1, 0, 1, 1, 0); endtask
  task automatic t_b2b;
    issue(6'd7, 32'hcafe_0000, 0, 0, 0, 0, 1, 0, 1, 1, 0);
    issue(6'd53, 32'h8000_0000, 1, 2, 1, 0, 1, 0, 1, 0, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset; t_nodata; t_short; t_long; t_nocrc; t_rd512; t_rdflush;
        t_wr; t_big; t_ext_m; t_ext_1; t_other_m; t_stop; t_b2b;
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule